// File: doc/BRIEF.md
# Approximate 8x8 Unsigned Multiplier with Recoded Partial Products

This block multiplies two unsigned operands and returns an approximate double-width product. Accuracy is traded for a smaller reduction stage. Every partial product starts as the AND of one bit of `a_i` with one bit of `b_i`.

In the middle columns of the partial-product matrix, each pair of mirror-image terms `a[i]&b[j]` and `a[j]&b[i]` (with i<j) is recoded. The pair becomes an OR term (propagate) and an AND term (generate). Because OR plus AND equals the sum of the two bits, the propagate term and the generate term both keep the column weight. The generate terms are rarely set. Within a column they are merged by a single OR, which costs one bit of column height instead of several adder inputs. The remaining bits are summed exactly by a carry-save array, and an exact ripple adder merges the sum and carry rows.

The result can never exceed the exact product, and it is exactly zero when either operand is zero. An optional output register gives one cycle of latency. With it, a downstream datapath can use the block as a single pipeline stage.

Top module: `appm_mul`

## Requirements
- R1: With `REG_OUT`=1, `p_o` shows, one clock after the rising edge that samples `a_i`/`b_i`, the exact product minus a correction. The correction is summed over columns c=3..11. For each such column it is (k-1)·2^c, where k is the number of pairs (i<j, i+j=c) whose generate term a[i]&b[j]&a[j]&b[i] is 1, and k≥1.
- R2: When either operand is zero, the product is zero.
- R3: Product bits [2:0] always equal bits [2:0] of the exact product.
- R4: The product never exceeds the exact product.
- R5: The exact product minus `p_o` never exceeds 5208. This is the sum over columns 3..11 of (pairs-1)·2^c.
- R6: When either operand has exactly one bit set, the product is exact.
- R7: While `rst_ni` is low, `p_o` is zero, whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_i | input | 8 | Multiplicand, unsigned |
| b_i | input | 8 | Multiplier, unsigned |
| p_o | output | 16 | Approximate product |

## Verification
The clocked checks assume that `a_i` and `b_i` carry known values that are stable around each rising edge. They also assume that the first edge after reset release does not yet carry a meaningful comparison. An internal arming flag skips that edge. The stimulus changes operands only on falling edges and holds them at zero while reset is released. It then walks all 65,536 operand pairs without gaps, so every comparison sees settled, fully defined inputs.

// File: rtl/appm_pkg.sv
`timescale 1ns/1ps
package appm_pkg;
  localparam int unsigned OP_W_DEF   = 8;
  localparam int unsigned REC_LO_DEF = 3;
  localparam int unsigned REC_HI_DEF = 11;

  // number of mirror pairs (i<j, i+j==c) in column c
  function automatic int unsigned pair_cnt(int unsigned op_w, int unsigned c);
    int unsigned n;
    n = 0;
    for (int unsigned i = 0; i < op_w; i++)
      for (int unsigned j = i + 1; j < op_w; j++)
        if (i + j == c) n++;
    return n;
  endfunction

  // worst-case loss from OR-merging generates
  function automatic int unsigned err_bound(int unsigned op_w, int unsigned lo, int unsigned hi);
    int unsigned s;
    s = 0;
    for (int unsigned c = lo; c <= hi; c++)
      if (pair_cnt(op_w, c) > 1) s += (pair_cnt(op_w, c) - 1) << c;
    return s;
  endfunction
endpackage

// File: rtl/appm_matrix.sv
`timescale 1ns/1ps
module appm_matrix #(
  parameter int unsigned OP_W   = appm_pkg::OP_W_DEF,
  parameter int unsigned REC_LO = appm_pkg::REC_LO_DEF,
  parameter int unsigned REC_HI = appm_pkg::REC_HI_DEF,
  localparam int unsigned PW    = 2 * OP_W
) (
  input  logic [OP_W-1:0]          a_i,
  input  logic [OP_W-1:0]          b_i,
  output logic [OP_W-1:0][PW-1:0]  rows_o
);
  logic [OP_W-1:0][OP_W-1:0] pp;

  for (genvar i = 0; i < OP_W; i++) begin : g_pp_i
    for (genvar j = 0; j < OP_W; j++) begin : g_pp_j
      assign pp[i][j] = a_i[i] & b_i[j];
    end
  end

  // slot k of column c holds the term with row index k; in recoded columns
  // slot OP_W-1 is free (k>j) and carries the OR of the generates
  for (genvar c = 0; c < PW; c++) begin : g_col
    localparam bit REC = (c >= REC_LO) && (c <= REC_HI);
    logic [OP_W-1:0] col;
    logic [OP_W-1:0] gen;

    for (genvar k = 0; k < OP_W; k++) begin : g_slot
      localparam int J = int'(c) - int'(k);
      localparam bit OK = (J >= 0) && (J < int'(OP_W));
      if (REC && k == OP_W - 1) begin : g_gor
        assign col[k] = |gen;
        assign gen[k] = 1'b0;
      end else if (OK && REC && int'(k) < J) begin : g_pair
        assign col[k] = pp[k][J] | pp[J][k];
        assign gen[k] = pp[k][J] & pp[J][k];
      end else if (OK && (!REC || int'(k) == J)) begin : g_pass
        assign col[k] = pp[k][J];
        assign gen[k] = 1'b0;
      end else begin : g_zero
        assign col[k] = 1'b0;
        assign gen[k] = 1'b0;
      end
      assign rows_o[k][c] = col[k];
    end
  end
endmodule

// File: rtl/appm_csa.sv
`timescale 1ns/1ps
module appm_csa #(
  parameter int unsigned N_ROWS = 8,
  parameter int unsigned PW     = 16
) (
  input  logic [N_ROWS-1:0][PW-1:0] rows_i,
  output logic [PW-1:0]             sum_o,
  output logic [PW-1:0]             carry_o
);
  logic [PW-1:0] s_l [1:N_ROWS-1];
  logic [PW-1:0] c_l [1:N_ROWS-1];

  assign s_l[1] = rows_i[0];
  assign c_l[1] = rows_i[1];

  // one full-adder row per additional input row
  for (genvar r = 2; r < N_ROWS; r++) begin : g_fa_row
    assign s_l[r] = s_l[r-1] ^ c_l[r-1] ^ rows_i[r];
    assign c_l[r] = ((s_l[r-1] & c_l[r-1]) | (s_l[r-1] & rows_i[r]) |
                     (c_l[r-1] & rows_i[r])) << 1;
  end

  assign sum_o   = s_l[N_ROWS-1];
  assign carry_o = c_l[N_ROWS-1];
endmodule

// File: rtl/appm_merge.sv
`timescale 1ns/1ps
module appm_merge #(
  parameter int unsigned PW = 16
) (
  input  logic [PW-1:0] x_i,
  input  logic [PW-1:0] y_i,
  output logic [PW-1:0] s_o
);
  logic [PW-1:0] cy;
  assign cy[0] = 1'b0;

  for (genvar k = 0; k < PW; k++) begin : g_bit
    assign s_o[k] = x_i[k] ^ y_i[k] ^ cy[k];
    if (k < PW - 1) begin : g_cy
      assign cy[k+1] = (x_i[k] & y_i[k]) | (cy[k] & (x_i[k] ^ y_i[k]));
    end
  end
endmodule

// File: rtl/appm_mul.sv
`timescale 1ns/1ps
module appm_mul #(
  parameter int unsigned OP_W    = appm_pkg::OP_W_DEF,
  parameter int unsigned REC_LO  = appm_pkg::REC_LO_DEF,
  parameter int unsigned REC_HI  = appm_pkg::REC_HI_DEF,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned PW     = 2 * OP_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OP_W-1:0] a_i,
  input  logic [OP_W-1:0] b_i,
  output logic [PW-1:0]   p_o
);
  localparam int unsigned ERR_MAX = appm_pkg::err_bound(OP_W, REC_LO, REC_HI);

  logic [OP_W-1:0][PW-1:0] rows;
  logic [PW-1:0]           sum_row, carry_row, prod;

  appm_matrix #(.OP_W(OP_W), .REC_LO(REC_LO), .REC_HI(REC_HI)) u_matrix (
    .a_i(a_i), .b_i(b_i), .rows_o(rows)
  );

  appm_csa #(.N_ROWS(OP_W), .PW(PW)) u_csa (
    .rows_i(rows), .sum_o(sum_row), .carry_o(carry_row)
  );

  appm_merge #(.PW(PW)) u_merge (
    .x_i(sum_row), .y_i(carry_row), .s_o(prod)
  );

  // checker-side exact reference
  logic [PW-1:0] exact;
  assign exact = PW'(a_i) * PW'(b_i);

  if (REG_OUT) begin : g_reg
    logic [PW-1:0] p_q;
    logic          armed;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        p_q   <= '0;
        armed <= 1'b0;
      end else begin
        p_q   <= prod;
        armed <= 1'b1;
      end
    end
    assign p_o = p_q;

    // R2
    zero_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed && (a_i == '0 || b_i == '0)) |=> p_o == '0);
    // R3
    low_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed |=> p_o[REC_LO-1:0] == $past(exact[REC_LO-1:0]));
    // R4
    no_overshoot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed |=> p_o <= $past(exact));
    // R5
    err_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed |=> (int'(p_o) + int'(ERR_MAX)) >= int'($past(exact)));
  end else begin : g_comb
    assign p_o = prod;

    // R2
    zero_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a_i == '0 || b_i == '0) |-> p_o == '0);
    // R3
    low_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      p_o[REC_LO-1:0] == exact[REC_LO-1:0]);
    // R4
    no_overshoot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      p_o <= exact);
    // R5
    err_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int'(p_o) + int'(ERR_MAX)) >= int'(exact));
  end
endmodule

// File: tb/appm_mul_test.sv
`timescale 1ns/1ps
module appm_mul_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  a_i = '0;
  logic [7:0]  b_i = '0;
  logic [15:0] p_o;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;
  bit          done = 1'b0;
  longint unsigned err_sum = 0;
  int unsigned err_max = 0;
  int unsigned bound;

  int unsigned qa[$];
  int unsigned qb[$];

  always #2 clk_i = ~clk_i;

  appm_mul uut (.clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .p_o(p_o));

  function automatic int unsigned bit_of(int unsigned v, int unsigned k);
    return (v >> k) & 1;
  endfunction

  function automatic int unsigned approx_ref(int unsigned x, int unsigned y);
    int unsigned drop, cnt;
    drop = 0;
    for (int unsigned c = 3; c <= 11; c++) begin
      cnt = 0;
      for (int unsigned i = 0; i < 8; i++)
        for (int unsigned j = i + 1; j < 8; j++)
          if (i + j == c)
            cnt += bit_of(x, i) & bit_of(y, j) & bit_of(x, j) & bit_of(y, i);
      if (cnt > 1) drop += (cnt - 1) << c;
    end
    return x * y - drop;
  endfunction

  function automatic int unsigned calc_bound();
    int unsigned s, n;
    s = 0;
    for (int unsigned c = 3; c <= 11; c++) begin
      n = 0;
      for (int unsigned i = 0; i < 8; i++)
        for (int unsigned j = i + 1; j < 8; j++)
          if (i + j == c) n++;
      if (n > 1) s += (n - 1) << c;
    end
    return s;
  endfunction

  function automatic bit one_hot(int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

  task automatic chk(input bit ok, input string req, input int unsigned act, input int unsigned exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare();
    int unsigned x, y, ex, ap, act;
    x = qa.pop_front();
    y = qb.pop_front();
    ex  = x * y;
    ap  = approx_ref(x, y);
    act = int'(p_o);
    chk(act == ap, "R1 approx product", act, ap);
    if (x == 0 || y == 0) chk(act == 0, "R2 zero operand", act, 0);
    chk((act & 7) == (ex & 7), "R3 low bits", act & 7, ex & 7);
    chk(act <= ex, "R4 no overshoot", act, ex);
    chk(act + bound >= ex, "R5 error bound", ex - act, bound);
    if (one_hot(x) || one_hot(y)) chk(act == ex, "R6 single-bit operand exact", act, ex);
    if (act <= ex) begin
      err_sum += ex - act;
      if (ex - act > err_max) err_max = ex - act;
    end
  endtask

  task automatic summary();
    $display("mean error distance %f, max error %0d", real'(err_sum) / 65536.0, err_max);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    bound = calc_bound();
    a_i = 8'h5A;
    b_i = 8'hC3;
    repeat (3) @(negedge clk_i);
    chk(p_o == 16'd0, "R7 reset value", p_o, 0);
    a_i = 8'hFF;
    b_i = 8'hFF;
    @(negedge clk_i);
    chk(p_o == 16'd0, "R7 reset holds", p_o, 0);
    a_i = '0;
    b_i = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        @(negedge clk_i);
        if (qa.size() != 0) compare();
        a_i = 8'(x);
        b_i = 8'(y);
        qa.push_back(x);
        qb.push_back(y);
      end
    end
    @(negedge clk_i);
    compare();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #700000;
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule